// File: doc/BRIEF.md
# ATA Task-File Register Block

This block holds the register file of one ATA device sitting on a shared parallel bus channel. The host reaches it through a register-strobe interface. A block select picks between the command block and the control block, a 3-bit address picks the register inside that block, and single-cycle read and write strobes carry 8-bit data. For 48-bit addressing, each of the five address and count registers (feature, sector count and the three LBA bytes) keeps a primary copy and a high-order shadow copy. A write moves the old primary value into the shadow. A high-order select bit in the control register decides which copy a read returns.

A small command state machine tracks the device-visible status. Its states are IDLE, BUSY, DRQ and RESET. The transitions are:
- IDLE to BUSY when a command write is accepted.
- BUSY to IDLE on `exec_done` without `exec_drq`.
- BUSY to DRQ on `exec_done` with `exec_drq`.
- DRQ to IDLE on `xfer_done`.
- Any state to RESET while the soft-reset bit is held.
- RESET to IDLE once that bit is cleared.

An accepted command write produces a one-cycle `cmd_valid` pulse carrying the opcode. The executor that acts on it is outside this block and reports back with `exec_done` and `xfer_done`. The block also keeps an interrupt-pending flag. A status read or a command write clears it, and the interrupt output can be masked.

Top module: `ata_regfile`

## Requirements
- R1: After `rst_n` the status register reads 0x50, sector count and LBA byte 0 read 0x01, LBA bytes 1 and 2 read 0x00, every shadow copy reads 0x00, the device register reads 0xA0, and `intrq` and `cmd_valid` are low.
- R2: A write accepted at command-block address 1 (feature), 2 (count), 3, 4 or 5 (LBA bytes 0..2) stores the new value in the primary copy and moves the previous primary value into that register's shadow.
- R3: While bit 7 of the control register (control block, address 6) is 1, reads of command-block addresses 2..5 return the shadow copy; while it is 0 they return the primary copy.
- R4: Any write to a command-block address clears control bit 7. Control writes are the only way to set it.
- R5: A write to the device register (command block, address 6) is always taken, even while busy. It stores the written value with bits 7 and 5 forced to 1. Bit 7 of this register has no influence on read-back selection.
- R6: A write to the command register (command block, address 7) is acted on only when device bit 4 equals the parameter `DEV_NUM`. If the state is IDLE, it yields a one-cycle `cmd_valid` with `cmd_opcode` equal to the written byte, and the status becomes 0xD0 (BSY set).
- R7: A command-register write that this device acts on clears the pending interrupt, whether or not it starts a command.
- R8: In BUSY, `exec_done` clears BSY and sets the pending interrupt. With `exec_drq` high the status becomes 0x58 (DRQ set), otherwise 0x50. In DRQ, `xfer_done` returns the status to 0x50.
- R9: Reading the status register (command block, address 7) clears the pending interrupt. Reading the alternate status (control block, address 6) returns the same value and leaves the interrupt pending.
- R10: Writes to addresses 1..5 have no effect while BSY is set. A command write starts nothing unless both BSY and DRQ are clear.
- R11: Setting control bit 2 (soft reset) holds the block in RESET with status 0x80. In RESET, all primary and shadow copies return to their R1 values, the pending interrupt is dropped, and a completion pulse arriving during or after the reset is ignored. Clearing the bit returns the status to 0x50.
- R12: Control bit 1 forces `intrq` low without clearing the pending flag. Clearing the bit lets the flag show again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_sel | input | 1 | 1 selects the control block, 0 the command block |
| addr | input | 3 | Register address within the selected block |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one cycle per access |
| rd | input | 1 | Read strobe, one cycle per access |
| rdata | output | 8 | Read data, combinational on address and select |
| exec_done | input | 1 | Completion pulse from the command executor |
| exec_drq | input | 1 | With exec_done: a data transfer phase follows |
| xfer_done | input | 1 | Data transfer phase finished |
| cmd_valid | output | 1 | One-cycle pulse for an accepted command |
| cmd_opcode | output | 8 | Opcode of the last accepted command |
| intrq | output | 1 | Interrupt request to the host |

## Verification
The checker assumes that `wr` and `rd` are never high in the same cycle. It also assumes that a status read or a command write never coincides with `exec_done`, and that `exec_done` and `xfer_done` are only pulsed in the state that expects them, apart from the deliberate stale completion around soft reset. The bench keeps to these assumptions by issuing every host access and every executor pulse from its own task. Each task drives its strobes for exactly one cycle on the falling edge, so no two of them overlap.

// File: rtl/ata_regfile_pkg.sv
package ata_regfile_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int NUM_PAIRS = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUSY,
        ST_DRQ,
        ST_RESET
    } ata_state_t;

    // command-block addresses
    localparam logic [ADDR_W-1:0] A_FEAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_LBA0 = 3'd3;
    localparam logic [ADDR_W-1:0] A_LBA1 = 3'd4;
    localparam logic [ADDR_W-1:0] A_LBA2 = 3'd5;
    localparam logic [ADDR_W-1:0] A_DEV  = 3'd6;
    localparam logic [ADDR_W-1:0] A_CMD  = 3'd7;
    // control-block address
    localparam logic [ADDR_W-1:0] A_CTL  = 3'd6;

    // bit positions
    localparam int CTL_HOB  = 7;
    localparam int CTL_SRST = 2;
    localparam int CTL_NIEN = 1;
    localparam int DEV_SEL  = 4;

    localparam logic [BYTE_W-1:0] DEV_FORCED = 8'hA0;
    localparam logic [BYTE_W-1:0] STAT_IDLE  = 8'h50;
    localparam logic [BYTE_W-1:0] STAT_BUSY  = 8'hD0;
    localparam logic [BYTE_W-1:0] STAT_DRQ   = 8'h58;
    localparam logic [BYTE_W-1:0] STAT_RST   = 8'h80;

    // pair index = address - 1; count and LBA byte 0 come up as 1
    function automatic logic [BYTE_W-1:0] pair_reset(input int idx);
        return (idx == 1 || idx == 2) ? 8'h01 : 8'h00;
    endfunction

endpackage

// File: rtl/ata_shadow_pair.sv
module ata_shadow_pair
    import ata_regfile_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] pri,
    output logic [BYTE_W-1:0] shd
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pri <= RST_VAL;
            shd <= '0;
        end else if (clr) begin
            pri <= RST_VAL;
            shd <= '0;
        end else if (we) begin
            shd <= pri;
            pri <= wdata;
        end
    end

endmodule

// File: rtl/ata_cmd_fsm.sv
module ata_cmd_fsm
    import ata_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst_hold,
    input  logic              cmd_go,
    input  logic              exec_done,
    input  logic              exec_drq,
    input  logic              xfer_done,
    input  logic              irq_clr,
    output ata_state_t        state,
    output logic              irq_pend,
    output logic              bsy,
    output logic [BYTE_W-1:0] status
);

    ata_state_t state_nx;

    always_comb begin
        state_nx = state;
        if (srst_hold) begin
            state_nx = ST_RESET;
        end else begin
            unique case (state)
                ST_IDLE:  if (cmd_go)    state_nx = ST_BUSY;
                ST_BUSY:  if (exec_done) state_nx = exec_drq ? ST_DRQ : ST_IDLE;
                ST_DRQ:   if (xfer_done) state_nx = ST_IDLE;
                ST_RESET: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                        irq_pend <= 1'b0;
        else if (srst_hold)                                irq_pend <= 1'b0;
        else if (state == ST_BUSY && exec_done)            irq_pend <= 1'b1;
        else if (irq_clr)                                  irq_pend <= 1'b0;
    end

    always_comb begin
        unique case (state)
            ST_IDLE:  begin status = STAT_IDLE; bsy = 1'b0; end
            ST_BUSY:  begin status = STAT_BUSY; bsy = 1'b1; end
            ST_DRQ:   begin status = STAT_DRQ;  bsy = 1'b0; end
            ST_RESET: begin status = STAT_RST;  bsy = 1'b1; end
        endcase
    end

endmodule

// File: rtl/ata_rd_mux.sv
module ata_rd_mux
    import ata_regfile_pkg::*;
(
    input  logic                               ctl_sel,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic                               hob,
    input  logic [NUM_PAIRS-1:0][BYTE_W-1:0]   pri,
    input  logic [NUM_PAIRS-1:0][BYTE_W-1:0]   shd,
    input  logic [BYTE_W-1:0]                  dev_q,
    input  logic [BYTE_W-1:0]                  status,
    output logic [BYTE_W-1:0]                  rdata
);

    logic [ADDR_W-1:0] idx;
    assign idx = addr - 3'd1;

    always_comb begin
        rdata = '0;
        if (ctl_sel) begin
            if (addr == A_CTL) rdata = status;
        end else begin
            case (addr)
                A_CNT, A_LBA0, A_LBA1, A_LBA2: rdata = hob ? shd[idx] : pri[idx];
                A_DEV:                         rdata = dev_q;
                A_CMD:                         rdata = status;
                default:                       rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ata_regfile.sv
module ata_regfile
    import ata_regfile_pkg::*;
#(
    parameter int DEV_NUM = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wr,
    input  logic              rd,
    output logic [BYTE_W-1:0] rdata,
    input  logic              exec_done,
    input  logic              exec_drq,
    input  logic              xfer_done,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_opcode,
    output logic              intrq
);

    localparam logic MY_DEV = 1'(DEV_NUM);

    logic [BYTE_W-1:0]              ctl_q;
    logic [BYTE_W-1:0]              dev_q;
    logic [NUM_PAIRS-1:0][BYTE_W-1:0] pri_q;
    logic [NUM_PAIRS-1:0][BYTE_W-1:0] shd_q;
    logic [BYTE_W-1:0]              status;
    ata_state_t                     state;
    logic                           irq_pend;
    logic                           bsy;
    logic                           srst_hold;
    logic                           wr_cmdblk;
    logic                           wr_ctl;
    logic                           cmd_hit;
    logic                           cmd_go;
    logic                           irq_clr;

    assign wr_cmdblk = wr && !ctl_sel;
    assign wr_ctl    = wr && ctl_sel && (addr == A_CTL);
    assign srst_hold = ctl_q[CTL_SRST];
    assign cmd_hit   = wr_cmdblk && (addr == A_CMD) && (dev_q[DEV_SEL] == MY_DEV);
    assign cmd_go    = cmd_hit && (state == ST_IDLE) && !srst_hold;
    assign irq_clr   = cmd_hit || (rd && !ctl_sel && addr == A_CMD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ctl_q <= '0;
        else if (wr_ctl)    ctl_q <= wdata;
        else if (wr_cmdblk) ctl_q[CTL_HOB] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              dev_q <= DEV_FORCED;
        else if (wr_cmdblk && addr == A_DEV)     dev_q <= wdata | DEV_FORCED;
    end

    generate
        for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
            ata_shadow_pair #(
                .RST_VAL(pair_reset(g))
            ) i_pair (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (srst_hold),
                .we    (wr_cmdblk && (addr == 3'(g + 1)) && !bsy),
                .wdata (wdata),
                .pri   (pri_q[g]),
                .shd   (shd_q[g])
            );
        end
    endgenerate

    ata_cmd_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst_hold (srst_hold),
        .cmd_go    (cmd_go),
        .exec_done (exec_done),
        .exec_drq  (exec_drq),
        .xfer_done (xfer_done),
        .irq_clr   (irq_clr),
        .state     (state),
        .irq_pend  (irq_pend),
        .bsy       (bsy),
        .status    (status)
    );

    ata_rd_mux i_mux (
        .ctl_sel (ctl_sel),
        .addr    (addr),
        .hob     (ctl_q[CTL_HOB]),
        .pri     (pri_q),
        .shd     (shd_q),
        .dev_q   (dev_q),
        .status  (status),
        .rdata   (rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid  <= 1'b0;
            cmd_opcode <= '0;
        end else begin
            cmd_valid <= cmd_go;
            if (cmd_go) cmd_opcode <= wdata;
        end
    end

    assign intrq = irq_pend && !ctl_q[CTL_NIEN];

endmodule

// File: rtl/ata_regfile_chk.sv
module ata_regfile_chk
    import ata_regfile_pkg::*;
(
    input logic                             clk,
    input logic                             rst_n,
    input logic                             ctl_sel,
    input logic [ADDR_W-1:0]                addr,
    input logic                             wr,
    input logic                             rd,
    input logic                             exec_done,
    input logic                             cmd_valid,
    input logic                             intrq,
    input logic [BYTE_W-1:0]                ctl_q,
    input logic [BYTE_W-1:0]                dev_q,
    input logic [NUM_PAIRS-1:0][BYTE_W-1:0] pri_q,
    input logic [NUM_PAIRS-1:0][BYTE_W-1:0] shd_q,
    input ata_state_t                       state,
    input logic                             irq_pend
);

    p_cnt_shadow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !ctl_sel && addr == A_CNT && state == ST_IDLE && !ctl_q[CTL_SRST])
        |=> shd_q[1] == $past(pri_q[1]));

    p_hob_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !ctl_sel) |=> !ctl_q[CTL_HOB]);

    p_dev_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_q[7] && dev_q[5]);

    p_cmd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_cmd_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> state == ST_BUSY);

    p_cmd_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !irq_pend);

    p_done_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && exec_done && !ctl_q[CTL_SRST]) |=> irq_pend);

    p_stat_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !ctl_sel && addr == A_CMD && !exec_done) |=> !irq_pend);

    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !ctl_q[CTL_SRST]) |=> $stable(pri_q));

    p_srst_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[CTL_SRST] |=> (state == ST_RESET && !irq_pend));

    p_nien_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[CTL_NIEN] |-> !intrq);

endmodule

bind ata_regfile ata_regfile_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_sel   (ctl_sel),
    .addr      (addr),
    .wr        (wr),
    .rd        (rd),
    .exec_done (exec_done),
    .cmd_valid (cmd_valid),
    .intrq     (intrq),
    .ctl_q     (ctl_q),
    .dev_q     (dev_q),
    .pri_q     (pri_q),
    .shd_q     (shd_q),
    .state     (state),
    .irq_pend  (irq_pend)
);

// File: tb/test_ata_regfile.sv
module test_ata_regfile;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_sel = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rdata;
    logic       exec_done = 1'b0;
    logic       exec_drq = 1'b0;
    logic       xfer_done = 1'b0;
    logic       cmd_valid;
    logic [7:0] cmd_opcode;
    logic       intrq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ata_regfile #(.DEV_NUM(0)) i_ata_regfile (
        .clk(clk), .rst_n(rst_n), .ctl_sel(ctl_sel), .addr(addr), .wdata(wdata),
        .wr(wr), .rd(rd), .rdata(rdata), .exec_done(exec_done), .exec_drq(exec_drq),
        .xfer_done(xfer_done), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .intrq(intrq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic cs, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        ctl_sel = cs; addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic host_rd(input logic cs, input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        ctl_sel = cs; addr = a; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic done_pulse(input logic drq);
        @(negedge clk);
        exec_done = 1'b1; exec_drq = drq;
        @(negedge clk);
        exec_done = 1'b0; exec_drq = 1'b0;
    endtask

    task automatic xfer_pulse();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 intrq", {7'd0, intrq}, 8'h00);
        check("R1 cmd_valid", {7'd0, cmd_valid}, 8'h00);
        host_rd(0, 3'd7, v); check("R1 status", v, 8'h50);
        host_rd(0, 3'd2, v); check("R1 count", v, 8'h01);
        host_rd(0, 3'd3, v); check("R1 lba0", v, 8'h01);
        host_rd(0, 3'd4, v); check("R1 lba1", v, 8'h00);
        host_rd(0, 3'd5, v); check("R1 lba2", v, 8'h00);
        host_rd(0, 3'd6, v); check("R1 device", v, 8'hA0);
        host_wr(1, 3'd6, 8'h80);
        host_rd(0, 3'd2, v); check("R1 count shadow", v, 8'h00);
        host_rd(0, 3'd3, v); check("R1 lba0 shadow", v, 8'h00);
        host_wr(1, 3'd6, 8'h00);
    endtask

    task automatic t_shadow();
        logic [7:0] v;
        host_wr(0, 3'd2, 8'h12);
        host_wr(0, 3'd2, 8'h34);
        host_wr(0, 3'd4, 8'hAA);
        host_wr(0, 3'd4, 8'hBB);
        host_rd(0, 3'd2, v); check("R2 count primary", v, 8'h34);
        host_rd(0, 3'd4, v); check("R2 lba1 primary", v, 8'hBB);
        host_wr(1, 3'd6, 8'h80);
        host_rd(0, 3'd2, v); check("R3 count shadow", v, 8'h12);
        host_rd(0, 3'd4, v); check("R3 lba1 shadow", v, 8'hAA);
        host_rd(0, 3'd3, v); check("R3 lba0 shadow", v, 8'h00);
        host_wr(0, 3'd5, 8'h55);
        host_rd(0, 3'd2, v); check("R4 hob cleared by write", v, 8'h34);
        host_rd(0, 3'd5, v); check("R2 lba2 primary", v, 8'h55);
    endtask

    task automatic t_device();
        logic [7:0] v;
        host_wr(0, 3'd6, 8'h00);
        host_rd(0, 3'd6, v); check("R5 device forced bits", v, 8'hA0);
        host_wr(0, 3'd6, 8'h8F);
        host_rd(0, 3'd6, v); check("R5 device stored", v, 8'hAF);
        host_rd(0, 3'd2, v); check("R5 device bit7 no hob", v, 8'h34);
        host_wr(0, 3'd6, 8'h00);
    endtask

    task automatic t_command();
        logic [7:0] v;
        host_wr(0, 3'd6, 8'h10);
        host_wr(0, 3'd7, 8'h20);
        check("R6 other device ignored", {7'd0, cmd_valid}, 8'h00);
        host_rd(1, 3'd6, v); check("R6 other device status", v, 8'h50);
        host_wr(0, 3'd6, 8'h00);
        host_wr(0, 3'd7, 8'h20);
        check("R6 cmd_valid", {7'd0, cmd_valid}, 8'h01);
        check("R6 opcode", cmd_opcode, 8'h20);
        @(negedge clk);
        check("R6 single pulse", {7'd0, cmd_valid}, 8'h00);
        host_rd(1, 3'd6, v); check("R6 busy status", v, 8'hD0);
        host_wr(0, 3'd2, 8'h77);
        host_rd(0, 3'd2, v); check("R10 count ignored while busy", v, 8'h34);
        host_wr(0, 3'd7, 8'h21);
        check("R10 command ignored while busy", {7'd0, cmd_valid}, 8'h00);
        done_pulse(1'b0);
        check("R8 intrq after done", {7'd0, intrq}, 8'h01);
        host_rd(1, 3'd6, v); check("R8 status after done", v, 8'h50);
        check("R9 alt status keeps intrq", {7'd0, intrq}, 8'h01);
        host_wr(1, 3'd6, 8'h02);
        check("R12 nien masks", {7'd0, intrq}, 8'h00);
        host_wr(1, 3'd6, 8'h00);
        check("R12 pending kept", {7'd0, intrq}, 8'h01);
        host_rd(0, 3'd7, v); check("R9 status value", v, 8'h50);
        check("R9 status read clears", {7'd0, intrq}, 8'h00);
    endtask

    task automatic t_drq_irq();
        logic [7:0] v;
        host_wr(0, 3'd7, 8'h30);
        check("R6 second command", cmd_opcode, 8'h30);
        done_pulse(1'b1);
        host_rd(1, 3'd6, v); check("R8 drq status", v, 8'h58);
        check("R8 intrq with drq", {7'd0, intrq}, 8'h01);
        host_wr(0, 3'd7, 8'h31);
        check("R10 command ignored in drq", {7'd0, cmd_valid}, 8'h00);
        check("R7 command write clears intrq", {7'd0, intrq}, 8'h00);
        xfer_pulse();
        host_rd(1, 3'd6, v); check("R8 after transfer", v, 8'h50);
        host_wr(0, 3'd7, 8'h32);
        done_pulse(1'b0);
        check("R7 pending before command", {7'd0, intrq}, 8'h01);
        host_wr(0, 3'd7, 8'h33);
        check("R7 accepted command", {7'd0, cmd_valid}, 8'h01);
        check("R7 intrq cleared", {7'd0, intrq}, 8'h00);
        done_pulse(1'b0);
        host_rd(0, 3'd7, v);
    endtask

    task automatic t_srst();
        logic [7:0] v;
        host_wr(0, 3'd2, 8'h99);
        host_wr(0, 3'd7, 8'h40);
        host_wr(1, 3'd6, 8'h04);
        host_rd(1, 3'd6, v); check("R11 reset status", v, 8'h80);
        done_pulse(1'b0);
        check("R11 done during reset ignored", {7'd0, intrq}, 8'h00);
        host_rd(0, 3'd2, v); check("R11 count restored", v, 8'h01);
        host_wr(1, 3'd6, 8'h00);
        host_rd(1, 3'd6, v); check("R11 status after release", v, 8'h50);
        done_pulse(1'b0);
        check("R11 stale done ignored", {7'd0, intrq}, 8'h00);
        host_rd(1, 3'd6, v); check("R11 still idle", v, 8'h50);
        host_wr(1, 3'd6, 8'h80);
        host_rd(0, 3'd2, v); check("R11 shadow cleared", v, 8'h00);
        host_wr(1, 3'd6, 8'h00);
        host_wr(0, 3'd7, 8'h50);
        check("R11 new command after reset", {7'd0, cmd_valid}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_shadow();
        t_device();
        t_command();
        t_drq_irq();
        t_srst();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule